// File: doc/BRIEF.md
# I2C Controller Interrupt and Enable-Status Unit

This unit collects the twelve event sources of an I2C controller into one interrupt line. Edge-type events, such as a stop condition or a transmit abort, set a sticky flag. The two FIFO threshold sources follow their level inputs directly. A mask register selects which flags reach the masked status view, and the interrupt line is the OR of that view.

Software clears sticky flags by reading registers, with no write needed. Each sticky source has its own clear address, and one further address clears every sticky flag in a single access.

The unit also holds the controller enable bit. The effect of that bit is reported through a separate status bit, which software polls. That status bit rises after a fixed synchronisation delay. When the controller is disabled, the bit falls only after the disable has passed through the synchroniser and the bus engine reports that it is idle.

Top module: `i2c_irq_unit`

## Requirements
- R1: Sources 11 (general call), 10 (start/restart), 9 (stop), 8 (activity), 7 (receive done), 6 (transmit abort), 5 (read request), 3 (transmit overflow), 1 (receive overflow) and 0 (receive underflow) are sticky. A high cycle on `evt_in[b]` sets raw status bit b, and the bit stays set until a clear read. Reading the raw status at address 2 has no side effect.
- R2: Bits 4 (transmit empty) and 2 (receive full) of the raw status equal `evt_in[4]` and `evt_in[2]` in the same cycle. No clear read changes them.
- R3: The mask register at address 0 is read/write, 12 bits wide, and resets to 0. The masked status at address 1 reads as raw status AND mask.
- R4: `irq` is high exactly when the masked status is nonzero.
- R5: A read of address 16+b returns, in bit 0, the current value of sticky bit b, and clears only that bit at the end of the access cycle. Addresses 18 and 20 read as 0 and clear nothing.
- R6: A read of address 3 returns, in bit 0, the OR of all sticky bits, and clears every sticky bit while leaving bits 4 and 2 alone.
- R7: If an event and a clear read of its bit fall in the same cycle, the bit stays set.
- R8: Writes to any address other than 0 and 4 change no state.
- R9: The enable register at address 4 (bit 0) is read/write, resets to 0, and drives `core_en` directly.
- R10: The enable-status bit at address 5 (bit 0) rises exactly SYNC_STAGES+1 clock edges after the edge that writes a 1 to the enable register.
- R11: After the enable register is cleared, the enable-status bit stays 1 until the synchronised enable is low and `eng_idle` is high at a clock edge. It falls on that edge.
- R12: After reset, the raw status, masked status, enable register and enable-status bit read as 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_sel | input | 1 | Register access in this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Word address |
| acc_wdata | input | 12 | Write data |
| acc_rdata | output | 12 | Read data, valid in the access cycle |
| evt_in | input | 12 | Event sources, indexed by status bit position |
| eng_idle | input | 1 | Bus engine is idle |
| core_en | output | 1 | Enable towards the controller core |
| irq | output | 1 | Interrupt request |

## Verification
The checker tests several properties on every cycle:
- a sticky bit never drops without a clear,
- an event arriving in the same cycle as a clear of its bit still sets the bit,
- no clear happens without a read,
- `irq` implies a nonzero mask,
- the enable-status bit moves only in the directions the enable register and the idle input allow.

Some behaviour only the directed scenarios can show:
- the exact edge at which enable status rises,
- that the status holds through a long busy period after disable,
- the values returned by the clear registers,
- that writes to status and clear addresses are ignored.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

  localparam int NSRC  = 12;
  localparam int SRC_W = $clog2(NSRC);

  // bit positions of the sources
  localparam int B_RX_UNDER  = 0;
  localparam int B_RX_OVER   = 1;
  localparam int B_RX_FULL   = 2;
  localparam int B_TX_OVER   = 3;
  localparam int B_TX_EMPTY  = 4;
  localparam int B_RD_REQ    = 5;
  localparam int B_TX_ABORT  = 6;
  localparam int B_RX_DONE   = 7;
  localparam int B_ACTIVITY  = 8;
  localparam int B_STOP_SEEN = 9;
  localparam int B_START_SEEN = 10;
  localparam int B_GEN_CALL  = 11;

  localparam logic [NSRC-1:0] LEVEL_SRC =
    NSRC'((1 << B_TX_EMPTY) | (1 << B_RX_FULL));
  localparam logic [NSRC-1:0] STICKY_SRC = ~LEVEL_SRC;

  // word addresses
  localparam int unsigned A_MASK     = 0;
  localparam int unsigned A_MSTAT    = 1;
  localparam int unsigned A_RSTAT    = 2;
  localparam int unsigned A_CLRALL   = 3;
  localparam int unsigned A_EN       = 4;
  localparam int unsigned A_ENSTAT   = 5;
  localparam int unsigned A_CLR_BASE = 16;

  typedef enum logic [2:0] {
    RS_NONE, RS_MASK, RS_MSTAT, RS_RSTAT, RS_CLRALL, RS_EN, RS_ENSTAT, RS_CLRSRC
  } rsel_e;

  function automatic logic src_clearable(input logic [SRC_W-1:0] idx);
    return (int'(idx) < NSRC) ? STICKY_SRC[idx] : 1'b0;
  endfunction

  function automatic logic [NSRC-1:0] masked_view(input logic [NSRC-1:0] raw,
                                                  input logic [NSRC-1:0] mask);
    return raw & mask;
  endfunction

  function automatic logic any_sticky(input logic [NSRC-1:0] raw);
    return |(raw & STICKY_SRC);
  endfunction

endpackage

// File: rtl/i2c_irq_decode.sv
module i2c_irq_decode
  import i2c_irq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                acc_sel,
  input  logic                acc_wr,
  input  logic [ADDR_W-1:0]   acc_addr,
  output rsel_e               rsel,
  output logic [SRC_W-1:0]    src_idx,
  output logic                wr_mask,
  output logic                wr_en,
  output logic                clr_all,
  output logic [NSRC-1:0]     clr_src
);

  localparam logic [ADDR_W-1:0] CLR_LO = ADDR_W'(A_CLR_BASE);
  localparam logic [ADDR_W-1:0] CLR_HI = ADDR_W'(A_CLR_BASE + NSRC);

  logic rd_strobe;
  logic wr_strobe;
  logic in_clr_window;

  assign rd_strobe     = acc_sel & ~acc_wr;
  assign wr_strobe     = acc_sel & acc_wr;
  assign in_clr_window = (acc_addr >= CLR_LO) && (acc_addr < CLR_HI);

  always_comb begin
    rsel    = RS_NONE;
    src_idx = '0;
    wr_mask = 1'b0;
    wr_en   = 1'b0;
    clr_all = 1'b0;
    clr_src = '0;
    if (acc_addr == ADDR_W'(A_MASK)) begin
      rsel    = RS_MASK;
      wr_mask = wr_strobe;
    end else if (acc_addr == ADDR_W'(A_MSTAT)) begin
      rsel = RS_MSTAT;
    end else if (acc_addr == ADDR_W'(A_RSTAT)) begin
      rsel = RS_RSTAT;
    end else if (acc_addr == ADDR_W'(A_CLRALL)) begin
      rsel    = RS_CLRALL;
      clr_all = rd_strobe;
    end else if (acc_addr == ADDR_W'(A_EN)) begin
      rsel  = RS_EN;
      wr_en = wr_strobe;
    end else if (acc_addr == ADDR_W'(A_ENSTAT)) begin
      rsel = RS_ENSTAT;
    end else if (in_clr_window) begin
      rsel    = RS_CLRSRC;
      src_idx = SRC_W'(acc_addr - CLR_LO);
      if (rd_strobe && src_clearable(src_idx))
        clr_src[src_idx] = 1'b1;
    end
  end

endmodule

// File: rtl/i2c_irq_src_bank.sv
module i2c_irq_src_bank
  import i2c_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_in,
  input  logic [NSRC-1:0] clr_vec,
  output logic [NSRC-1:0] raw
);

  for (genvar b = 0; b < NSRC; b++) begin : g_src
    if (LEVEL_SRC[b]) begin : g_level
      assign raw[b] = evt_in[b];
    end else begin : g_sticky
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= evt_in[b] | (flag_q & ~clr_vec[b]);
      end
      assign raw[b] = flag_q;
    end
  end

endmodule

// File: rtl/i2c_irq_en_sync.sv
module i2c_irq_en_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_req,
  input  logic eng_idle,
  output logic en_synced,
  output logic en_stat
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= en_req;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[k] <= 1'b0;
      else        chain_q[k] <= chain_q[k-1];
    end
  end

  assign en_synced = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         en_stat <= 1'b0;
    else if (en_synced) en_stat <= 1'b1;
    else if (eng_idle)  en_stat <= 1'b0;
  end

endmodule

// File: rtl/i2c_irq_unit.sv
module i2c_irq_unit
  import i2c_irq_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_sel,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [NSRC-1:0]   acc_wdata,
  output logic [NSRC-1:0]   acc_rdata,
  input  logic [NSRC-1:0]   evt_in,
  input  logic              eng_idle,
  output logic              core_en,
  output logic              irq
);

  rsel_e            rsel;
  logic [SRC_W-1:0] src_idx;
  logic             wr_mask;
  logic             wr_en;
  logic             clr_all;
  logic [NSRC-1:0]  clr_src;
  logic [NSRC-1:0]  clr_vec;
  logic [NSRC-1:0]  raw;
  logic [NSRC-1:0]  mstat;
  logic [NSRC-1:0]  mask_q;
  logic             en_q;
  logic             en_synced;
  logic             en_stat;

  i2c_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
    .acc_sel (acc_sel),
    .acc_wr  (acc_wr),
    .acc_addr(acc_addr),
    .rsel    (rsel),
    .src_idx (src_idx),
    .wr_mask (wr_mask),
    .wr_en   (wr_en),
    .clr_all (clr_all),
    .clr_src (clr_src)
  );

  assign clr_vec = clr_src | ({NSRC{clr_all}} & STICKY_SRC);

  i2c_irq_src_bank u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_in (evt_in),
    .clr_vec(clr_vec),
    .raw    (raw)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (wr_mask) mask_q <= acc_wdata;
      if (wr_en)   en_q   <= acc_wdata[0];
    end
  end

  i2c_irq_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_req   (en_q),
    .eng_idle (eng_idle),
    .en_synced(en_synced),
    .en_stat  (en_stat)
  );

  assign mstat   = masked_view(raw, mask_q);
  assign irq     = |mstat;
  assign core_en = en_q;

  always_comb begin
    acc_rdata = '0;
    unique case (rsel)
      RS_MASK:   acc_rdata = mask_q;
      RS_MSTAT:  acc_rdata = mstat;
      RS_RSTAT:  acc_rdata = raw;
      RS_CLRALL: acc_rdata = NSRC'(any_sticky(raw));
      RS_EN:     acc_rdata = NSRC'(en_q);
      RS_ENSTAT: acc_rdata = NSRC'(en_stat);
      RS_CLRSRC: acc_rdata = NSRC'(raw[src_idx] & src_clearable(src_idx));
      default:   acc_rdata = '0;
    endcase
  end

endmodule

// File: rtl/i2c_irq_unit_chk.sv
module i2c_irq_unit_chk
  import i2c_irq_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            acc_sel,
  input logic            acc_wr,
  input logic [NSRC-1:0] evt_in,
  input logic [NSRC-1:0] raw,
  input logic [NSRC-1:0] clr_vec,
  input logic [NSRC-1:0] mask_q,
  input logic            irq,
  input logic            core_en,
  input logic            en_synced,
  input logic            en_stat,
  input logic            eng_idle
);

  // sticky flags drop only when a clear names them
  assert_sticky_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw & $past(raw & ~clr_vec & STICKY_SRC)) ==
              $past(raw & ~clr_vec & STICKY_SRC)));

  // an incoming event wins over a same-cycle clear
  assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw & $past(evt_in & STICKY_SRC)) == $past(evt_in & STICKY_SRC)));

  // no clear without a read access
  assert_clear_needs_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_sel && !acc_wr) |-> (clr_vec == '0));

  // interrupt needs an unmasked source
  assert_irq_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != '0) && (raw != '0));

  // status rises only behind a set enable
  assert_stat_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_stat) |-> $past(core_en) && $past(en_synced));

  // status falls only when disabled and idle
  assert_stat_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_stat) |-> $past(eng_idle) && !$past(en_synced));

endmodule

bind i2c_irq_unit i2c_irq_unit_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .acc_sel  (acc_sel),
  .acc_wr   (acc_wr),
  .evt_in   (evt_in),
  .raw      (raw),
  .clr_vec  (clr_vec),
  .mask_q   (mask_q),
  .irq      (irq),
  .core_en  (core_en),
  .en_synced(en_synced),
  .en_stat  (en_stat),
  .eng_idle (eng_idle)
);

// File: tb/tb_i2c_irq_unit.sv
module tb_i2c_irq_unit;

  localparam int AW   = 6;
  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_sel = 1'b0;
  logic        acc_wr = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [11:0] acc_wdata = '0;
  logic [11:0] acc_rdata;
  logic [11:0] ev_pulse = '0;
  logic [11:0] ev_lvl = '0;
  logic [11:0] evt_in;
  logic        eng_idle = 1'b1;
  logic        core_en;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  assign evt_in = ev_pulse | ev_lvl;

  always #2.5 clk = ~clk;

  i2c_irq_unit #(.ADDR_W(AW), .SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst_n(rst_n), .acc_sel(acc_sel), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .evt_in(evt_in), .eng_idle(eng_idle), .core_en(core_en), .irq(irq)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic rd(input int a, output logic [11:0] d);
    acc_sel = 1'b1; acc_wr = 1'b0; acc_addr = AW'(a);
    #1 d = acc_rdata;
    @(negedge clk);
    acc_sel = 1'b0;
  endtask

  task automatic wr(input int a, input logic [11:0] d);
    acc_sel = 1'b1; acc_wr = 1'b1; acc_addr = AW'(a); acc_wdata = d;
    @(negedge clk);
    acc_sel = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic pulse(input logic [11:0] v);
    ev_pulse = v;
    @(negedge clk);
    ev_pulse = '0;
  endtask

  task automatic t_reset;
    logic [11:0] d;
    rd(2, d); chk("R12 raw", d, 0);
    rd(1, d); chk("R12 masked", d, 0);
    rd(4, d); chk("R12 enable", d, 0);
    rd(5, d); chk("R12 enstat", d, 0);
    chk("R12 irq", irq, 0);
  endtask

  task automatic t_latch;
    logic [11:0] d;
    pulse(12'h809);
    repeat (3) @(negedge clk);
    rd(2, d); chk("R1 sticky after pulse", d, 'h809);
    rd(2, d); chk("R1 raw read no side effect", d, 'h809);
    chk("R4 irq masked off", irq, 0);
  endtask

  task automatic t_mask;
    logic [11:0] d;
    wr(0, 12'h008);
    rd(0, d); chk("R3 mask readback", d, 'h008);
    rd(1, d); chk("R3 masked status", d, 'h008);
    chk("R4 irq on", irq, 1);
  endtask

  task automatic t_clr_single;
    logic [11:0] d;
    rd(16 + 3, d); chk("R5 clear returns bit", d, 1);
    rd(2, d);      chk("R5 only bit 3 cleared", d, 'h801);
    chk("R4 irq off after clear", irq, 0);
    rd(16 + 3, d); chk("R5 second clear reads 0", d, 0);
  endtask

  task automatic t_level;
    logic [11:0] d;
    ev_lvl = 12'h014;
    #1 chk("R2 level same cycle", acc_rdata | 12'h0, acc_rdata);
    rd(2, d);  chk("R2 level in raw", d, 'h815);
    rd(18, d); chk("R5 level clear addr 18 reads 0", d, 0);
    rd(20, d); chk("R5 level clear addr 20 reads 0", d, 0);
    rd(2, d);  chk("R2 level untouched by clear", d, 'h815);
    rd(3, d);  chk("R6 combined returns 1", d, 1);
    rd(2, d);  chk("R6 sticky cleared, level kept", d, 'h014);
    rd(3, d);  chk("R6 combined with none sticky", d, 0);
    ev_lvl = 12'h000;
    #1;
    rd(2, d);  chk("R2 level follows input low", d, 0);
  endtask

  task automatic t_coincide;
    logic [11:0] d;
    pulse(12'h020);
    acc_sel = 1'b1; acc_wr = 1'b0; acc_addr = AW'(16 + 5); ev_pulse = 12'h020;
    @(negedge clk);
    acc_sel = 1'b0; ev_pulse = '0;
    rd(2, d); chk("R7 event beats clear", d, 'h020);
    acc_sel = 1'b1; acc_wr = 1'b0; acc_addr = AW'(3); ev_pulse = 12'h400;
    @(negedge clk);
    acc_sel = 1'b0; ev_pulse = '0;
    rd(2, d); chk("R7 event beats combined clear", d, 'h400);
    rd(3, d);
  endtask

  task automatic t_wr_ignore;
    logic [11:0] d;
    pulse(12'h040);
    wr(2, 12'h000);
    wr(1, 12'h000);
    wr(3, 12'hfff);
    wr(16 + 6, 12'hfff);
    wr(5, 12'h001);
    rd(2, d); chk("R8 writes leave raw", d, 'h040);
    rd(5, d); chk("R8 write to enstat ignored", d, 0);
    rd(0, d); chk("R8 mask unchanged", d, 'h008);
    rd(3, d);
  endtask

  task automatic t_enable;
    logic [11:0] d;
    int first;
    wr(4, 12'h001);
    chk("R9 core_en follows write", core_en, 1);
    acc_sel = 1'b1; acc_wr = 1'b0; acc_addr = AW'(5);
    first = -1;
    for (int k = 0; k < 8; k++) begin
      #1 if (acc_rdata[0] && first < 0) first = k;
      @(negedge clk);
    end
    acc_sel = 1'b0;
    chk("R10 enable status latency", first, SYNC + 1);
    eng_idle = 1'b0;
    wr(4, 12'h000);
    chk("R9 core_en drops", core_en, 0);
    repeat (10) @(negedge clk);
    rd(5, d); chk("R11 held while busy", d, 1);
    eng_idle = 1'b1;
    #1;
    rd(5, d); chk("R11 still set before idle edge", d, 1);
    rd(5, d); chk("R11 cleared after idle edge", d, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch();
    t_mask();
    t_clr_single();
    t_level();
    t_coincide();
    t_wr_ignore();
    t_enable();
    finish_run();
  end

endmodule